// File: doc/BRIEF.md
# Nibble-Bus Instruction Store Loader

This block holds a small bank of 8-bit instruction words that is reached only through a 4-bit data bus. A load is a fixed sequence. A request latches the target address. The next two bus transfers fill an input byte buffer, opcode nibble first and operand nibble second. The assembled byte is then written into the addressed row. A read latches the address and fetches the row into an output byte buffer. It then returns the byte over the bus in two consecutive transfers.

The address register feeds a row decoder. A write strobe or a read strobe qualifies the decoder, so at most one row is enabled at a time. Only one sequence runs at a time. Requests that arrive while a sequence is in flight are dropped, and `busy_o` shows when this happens. Addresses beyond the last row are harmless. Writes to them change nothing, and reads from them return zero.

Top module: `imem_nibble_loader`

## Requirements
- R1: After reset, `busy_o`, `nib_valid_o` and `load_done_o` are 0 and every row (addresses 0 to 9) reads back as 0x00.
- R2: A load is accepted on a rising edge where `load_req_i`=1 and `busy_o`=0, and `addr_i` is latched on that edge. The next edge captures `nib_i` as the opcode nibble (stored byte bits [3:0]). The edge after that captures `nib_i` as the operand nibble (bits [7:4]). The fourth edge writes the byte. `busy_o` is 1 for the three cycles between the accept edge and the write edge.
- R3: `load_done_o` is 1 for exactly the one cycle that follows the write edge, and is 0 at all other times.
- R4: A read is accepted on an edge where `read_req_i`=1 and `busy_o`=0. The cycle after it is a fetch cycle with `nib_valid_o`=0. Then `nib_valid_o`=1 for two cycles, carrying bits [3:0] first and bits [7:4] second. `busy_o` is 1 for those three cycles.
- R5: Loads to addresses 10 to 15 change no row, and reads from them return two zero nibbles.
- R6: A load changes only the addressed row. Every other row keeps its content.
- R7: `load_req_i` and `read_req_i` are ignored while `busy_o`=1. The running sequence keeps its latched address, and no extra sequence follows it.
- R8: When `load_req_i` and `read_req_i` are both 1 in an idle cycle, the load is taken and the read is dropped.
- R9: `nib_o` is 0 whenever `nib_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_req_i | input | 1 | Start a load sequence |
| read_req_i | input | 1 | Start a read sequence |
| addr_i | input | 4 | Row address, latched on request accept |
| nib_i | input | 4 | Inbound nibble bus |
| nib_o | output | 4 | Outbound nibble bus |
| nib_valid_o | output | 1 | Outbound nibble is valid |
| load_done_o | output | 1 | One-cycle pulse after a row write |
| busy_o | output | 1 | A sequence is in progress |

## Verification
The hardest case to reach is a request that collides with a sequence already in flight. It has to arrive in exactly the opcode or operand step, and it has to carry a different address. The bench drives both request lines with a foreign address during those middle steps of many loads. It then reads back every address, in range and out of range, and compares the result with its own model. A hijacked address or a stray extra write shows up as a mismatch in some row. A separate idle-cycle test raises both requests together to check that the load is taken.

// File: rtl/imem_ldr_pkg.sv
package imem_ldr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_OPR, ST_WR, ST_FETCH, ST_RLO, ST_RHI
  } seq_st_e;
endpackage

// File: rtl/imem_seq_ctrl.sv
module imem_seq_ctrl
  import imem_ldr_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    load_req_i,
  input  logic    read_req_i,
  output seq_st_e state_o,
  output logic    accept_o,
  output logic    load_done_o
);
  seq_st_e st_q, st_d;

  assign accept_o = (st_q == ST_IDLE) && (load_req_i || read_req_i);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (load_req_i) st_d = ST_OPC;       // load wins a tie
                else if (read_req_i) st_d = ST_FETCH;
      ST_OPC:   st_d = ST_OPR;
      ST_OPR:   st_d = ST_WR;
      ST_WR:    st_d = ST_IDLE;
      ST_FETCH: st_d = ST_RLO;
      ST_RLO:   st_d = ST_RHI;
      ST_RHI:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      load_done_o <= 1'b0;
    end else begin
      st_q        <= st_d;
      load_done_o <= (st_q == ST_WR);
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/imem_addr_dec.sv
module imem_addr_dec #(
  parameter int unsigned DEPTH  = 10,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_ld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_stb_i,
  input  logic              rd_stb_i,
  output logic [DEPTH-1:0]  wr_row_o,
  output logic [DEPTH-1:0]  rd_row_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        addr_q <= '0;
    else if (addr_ld_i) addr_q <= addr_i;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    logic hit;
    assign hit         = (addr_q == ADDR_W'(i));
    assign wr_row_o[i] = hit & wr_stb_i;
    assign rd_row_o[i] = hit & rd_stb_i;
  end
endmodule

// File: rtl/imem_store.sv
module imem_store #(
  parameter int unsigned DEPTH  = 10,
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DEPTH-1:0]  wr_row_i,
  input  logic [DEPTH-1:0]  rd_row_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] row_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          row_q[i] <= '0;
      else if (wr_row_i[i]) row_q[i] <= wdata_i;
    end
  end

  // and-or mux: no row selected yields zero
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < DEPTH; i++)
      rdata_o |= row_q[i] & {WORD_W{rd_row_i[i]}};
  end
endmodule

// File: rtl/imem_nibble_loader.sv
module imem_nibble_loader
  import imem_ldr_pkg::*;
#(
  parameter int unsigned DEPTH  = 10,
  parameter int unsigned NIB_W  = 4,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_req_i,
  input  logic              read_req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NIB_W-1:0]  nib_i,
  output logic [NIB_W-1:0]  nib_o,
  output logic              nib_valid_o,
  output logic              load_done_o,
  output logic              busy_o
);
  localparam int unsigned WORD_W = 2 * NIB_W;

  seq_st_e           state;
  logic              accept;
  logic [DEPTH-1:0]  wr_row, rd_row;
  logic [WORD_W-1:0] in_buf_q, out_buf_q, rdata;

  imem_seq_ctrl u_ctrl (
    .clk_i, .rst_ni, .load_req_i, .read_req_i,
    .state_o(state), .accept_o(accept), .load_done_o
  );

  imem_addr_dec #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dec (
    .clk_i, .rst_ni,
    .addr_ld_i(accept), .addr_i,
    .wr_stb_i(state == ST_WR), .rd_stb_i(state == ST_FETCH),
    .wr_row_o(wr_row), .rd_row_o(rd_row)
  );

  imem_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk_i, .rst_ni,
    .wr_row_i(wr_row), .rd_row_i(rd_row),
    .wdata_i(in_buf_q), .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_buf_q  <= '0;
      out_buf_q <= '0;
    end else begin
      if (state == ST_OPC)   in_buf_q[NIB_W-1:0]      <= nib_i;
      if (state == ST_OPR)   in_buf_q[WORD_W-1:NIB_W] <= nib_i;
      if (state == ST_FETCH) out_buf_q                <= rdata;
    end
  end

  always_comb begin
    unique case (state)
      ST_RLO:  nib_o = out_buf_q[NIB_W-1:0];
      ST_RHI:  nib_o = out_buf_q[WORD_W-1:NIB_W];
      default: nib_o = '0;
    endcase
  end

  assign nib_valid_o = (state == ST_RLO) || (state == ST_RHI);
  assign busy_o      = (state != ST_IDLE);
endmodule

// File: rtl/imem_loader_chk.sv
module imem_loader_chk #(
  parameter int unsigned DEPTH = 10,
  parameter int unsigned NIB_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_req_i,
  input logic             read_req_i,
  input logic             busy_o,
  input logic             nib_valid_o,
  input logic             load_done_o,
  input logic [NIB_W-1:0] nib_o,
  input logic [DEPTH-1:0] wr_row,
  input logic [DEPTH-1:0] rd_row
);
  AST_ROW_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_row) && $onehot0(rd_row)) else $error("row enable"); // R6

  AST_NO_WRITE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (wr_row == '0)) else $error("idle write"); // R7

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_done_o |=> !load_done_o) else $error("done width"); // R3

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_done_o |-> !busy_o || nib_valid_o == 1'b0) else $error("done"); // R3

  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (load_req_i || read_req_i)) |=> busy_o) else $error("accept"); // R2

  AST_VALID_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nib_valid_o) |=> nib_valid_o) else $error("valid pair"); // R4

  AST_VALID_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nib_valid_o && $past(nib_valid_o)) |=> !nib_valid_o) else $error("valid end"); // R4

  AST_BUS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nib_valid_o |-> (nib_o == '0)) else $error("bus quiet"); // R9
endmodule

bind imem_nibble_loader imem_loader_chk #(.DEPTH(DEPTH), .NIB_W(NIB_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_req_i(load_req_i), .read_req_i(read_req_i),
  .busy_o(busy_o), .nib_valid_o(nib_valid_o), .load_done_o(load_done_o),
  .nib_o(nib_o), .wr_row(wr_row), .rd_row(rd_row)
);

// File: tb/imem_nibble_loader_test.sv
module imem_nibble_loader_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_req = 1'b0, read_req = 1'b0;
  logic [3:0] addr = '0, nib_in = '0;
  logic [3:0] nib_out;
  logic       nib_valid, load_done, busy;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] model [16];

  always #4 clk = ~clk;

  imem_nibble_loader uut (
    .clk_i(clk), .rst_ni(rst_n), .load_req_i(load_req), .read_req_i(read_req),
    .addr_i(addr), .nib_i(nib_in), .nib_o(nib_out), .nib_valid_o(nib_valid),
    .load_done_o(load_done), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // foreign: drive both requests with another address during opcode/operand steps (R7)
  // both: raise read_req together with load_req in the accept cycle (R8)
  task automatic do_load(input logic [3:0] a, input logic [7:0] v,
                         input bit foreign, input bit both);
    @(negedge clk);
    load_req = 1'b1; read_req = both; addr = a;
    @(negedge clk);
    chk(busy == 1'b1, "R2 busy opc", busy, 1);
    load_req = foreign; read_req = foreign; addr = ~a;
    nib_in = v[3:0];
    @(negedge clk);
    chk(busy == 1'b1 && nib_valid == 1'b0, "R2 busy opr", busy, 1);
    if (both) chk(nib_valid == 1'b0, "R8 no read", nib_valid, 0);
    nib_in = v[7:4];
    @(negedge clk);
    load_req = 1'b0; read_req = 1'b0; nib_in = '0;
    chk(busy == 1'b1 && load_done == 1'b0, "R3 no early done", load_done, 0);
    @(negedge clk);
    chk(load_done == 1'b1, "R3 done pulse", load_done, 1);
    chk(busy == 1'b0, "R7 no extra sequence", busy, 0);
    @(negedge clk);
    chk(load_done == 1'b0, "R3 done width", load_done, 0);
    if (a < 4'd10) model[a] = v;
  endtask

  task automatic do_read(input logic [3:0] a, input string tag);
    logic [7:0] e;
    e = model[a];
    @(negedge clk);
    read_req = 1'b1; addr = a;
    @(negedge clk);
    read_req = 1'b0;
    chk(busy && !nib_valid && nib_out == 4'h0, {tag, " R4 fetch R9"}, nib_out, 0);
    @(negedge clk);
    chk(nib_valid && nib_out == e[3:0], {tag, " R4 low"}, nib_out, e[3:0]);
    @(negedge clk);
    chk(nib_valid && nib_out == e[7:4], {tag, " R4 high"}, nib_out, e[7:4]);
    @(negedge clk);
    chk(!nib_valid && !busy && nib_out == 4'h0, {tag, " R4 end R9"}, nib_out, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(busy == 0 && nib_valid == 0 && load_done == 0 && nib_out == 0,
        "R1 reset outputs", {busy, nib_valid, load_done}, 0);
    rst_n = 1'b1;
    for (int a = 0; a < 16; a++) do_read(4'(a), "R1 reset row");

    // pattern 1: all addresses, out-of-range ones must not stick (R5, R6)
    for (int a = 0; a < 16; a++) do_load(4'(a), 8'((a * 37 + 11) & 8'hFF), 0, 0);
    for (int a = 0; a < 16; a++) do_read(4'(a), (a >= 10) ? "R5 pat1" : "R6 pat1");

    // pattern 2: foreign requests injected during each load (R7)
    for (int a = 15; a >= 0; a--) do_load(4'(a), ~8'((a * 53 + 5) & 8'hFF), 1, 0);
    for (int a = 0; a < 16; a++) do_read(4'(a), "R7 pat2");

    // single-row rewrites: neighbours unchanged (R6)
    for (int a = 0; a < 10; a += 3) begin
      do_load(4'(a), 8'(8'hA5 ^ a), 0, 0);
      for (int b = 0; b < 10; b++) do_read(4'(b), "R6 single");
    end

    // simultaneous requests in idle (R8)
    do_load(4'd4, 8'h3C, 0, 1);
    do_read(4'd4, "R8 load taken");
    do_load(4'd12, 8'hFF, 0, 1);
    do_read(4'd12, "R5 R8 high addr");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule